// File: doc/BRIEF.md
# Reference Clock Period Calculator

This block works out the periods of two peripheral reference clocks from an input reference period and four configuration words. Three PLL control words each describe one PLL: an I/O PLL, a CPU PLL and a memory PLL. A fourth control word is shared by both peripheral outputs and holds a source selector, a 6-bit divisor and one enable bit per output. The block toggles no clock. It does period arithmetic: a PLL with multiplier M divides the period by M, and a peripheral divisor D multiplies it by D.

A change on any input word or on the input period starts a new calculation. Reset release starts one as well. The three PLL divisions run in parallel on multi-cycle sequential dividers. While a calculation is running, `busy` stays high. When it finishes, both output periods are updated at the same edge as a one-cycle `done` pulse. A period of zero means the clock is stopped.

Top module: `refper_calc`

## Requirements
- R1: If bit 4 (force bypass) of a PLL control word is set, that PLL's period equals the input period, whatever bits 0 and 1 hold.
- R2: If bypass is clear and bit 0 (PLL reset) or bit 1 (power-down) is set, that PLL's period is 0.
- R3: Otherwise the PLL period is the input period divided by the multiplier in bits 18:12, rounded down. A multiplier of 0 gives period 0.
- R4: Bits 5:4 of the clock control word select the source: values 0 and 1 pick the I/O PLL, 2 picks the CPU PLL, 3 picks the memory PLL.
- R5: Bit 0 of the clock control word enables output 0 and bit 1 enables output 1. A disabled output reports period 0.
- R6: An enabled output's period is the selected PLL period times the divisor in bits 13:8. A divisor of 0 counts as 1. The full 63 times the largest input period fits the output width.
- R7: While `rst_n` is low, both output periods, `busy` and `done` are 0. After release, a calculation runs on the present inputs and ends with a `done` pulse.
- R8: Any change of the input period or of a control word starts a calculation. `busy` is high from the cycle after the change until `done`. `done` lasts one cycle. The outputs change only on a `done` cycle.
- R9: PLL control bits other than 0, 1, 4 and 18:12 (including bit 3) do not affect the result. With the reset word 0x0001A008 (multiplier 26), the PLL period is the input period divided by 26.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_period | input | PW | Input reference period |
| io_pll_ctrl | input | CW | I/O PLL control word |
| cpu_pll_ctrl | input | CW | CPU PLL control word |
| mem_pll_ctrl | input | CW | Memory PLL control word |
| clk_ctrl | input | CW | Shared peripheral clock control word |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse when new periods are valid |
| out0_period | output | PW+6 | Period of peripheral clock 0 |
| out1_period | output | PW+6 | Period of peripheral clock 1 |

## Verification
The vector table walks each source selector value, including both codes that select the I/O PLL, against PLLs set to different multipliers. A wrong mux leg therefore shows up as a different number. Separate vectors set bypass together with PLL reset, reset alone, and power-down alone, which tells bypass precedence apart from the disable path. Other vectors pair multipliers 0, 1, 7 and 127 with divisors 0, 1, 2, 3 and 63. These check floor rounding, the zero-divisor rule and the widest product. Directed tests set only the bits that must be ignored, assert reset in the middle of a calculation, and enable one output at a time so that the enables cannot be swapped unnoticed.

// File: rtl/refper_pkg.sv
package refper_pkg;
   // PLL control word field positions
   localparam int PLL_RST_BIT = 0;
   localparam int PLL_PD_BIT  = 1;
   localparam int PLL_BYP_BIT = 4;
   localparam int PLL_MUL_LSB = 12;
   localparam int PLL_MUL_W   = 7;
   // peripheral clock control word field positions
   localparam int CK_EN_LSB   = 0;
   localparam int CK_SRC_LSB  = 4;
   localparam int CK_SRC_W    = 2;
   localparam int CK_DIV_LSB  = 8;
   localparam int CK_DIV_W    = 6;
   localparam int NUM_PLL     = 3;
   localparam int NUM_OUT     = 2;
   localparam int PLL_IO      = 0;
   localparam int PLL_CPU     = 1;
   localparam int PLL_MEM     = 2;

   typedef enum logic [1:0] {
      SRC_IO_A = 2'd0,
      SRC_IO_B = 2'd1,
      SRC_CPU  = 2'd2,
      SRC_MEM  = 2'd3
   } src_e;

   typedef enum logic [1:0] {
      CALC_IDLE = 2'd0,
      CALC_LOAD = 2'd1,
      CALC_RUN  = 2'd2
   } calc_st_e;
endpackage

// File: rtl/refper_divider.sv
module refper_divider #(
   parameter int DW = 24,
   parameter int SW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] dividend,
   input  logic [SW-1:0] divisor,
   output logic          fin,
   output logic [DW-1:0] quotient
);
   localparam int CNTW = $clog2(DW + 1);

   logic [DW-1:0]   quo_q;
   logic [SW-1:0]   rem_q;
   logic [SW-1:0]   dsr_q;
   logic [CNTW-1:0] cnt_q;
   logic            act_q;
   logic [SW:0]     shifted;
   logic [SW:0]     trial;

   if (DW < 2) begin : g_bad_dw
      $error("refper_divider: DW must be at least 2");
   end

   always_comb begin
      shifted = {rem_q, quo_q[DW-1]};
      trial   = shifted - {1'b0, dsr_q};
   end

   // restoring division, one quotient bit per cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo_q <= '0;
         rem_q <= '0;
         dsr_q <= '0;
         cnt_q <= '0;
         act_q <= 1'b0;
      end else if (start) begin
         quo_q <= dividend;
         rem_q <= '0;
         dsr_q <= divisor;
         cnt_q <= CNTW'(DW);
         act_q <= 1'b1;
      end else if (act_q) begin
         if (cnt_q != '0) begin
            if (!trial[SW]) begin
               rem_q <= trial[SW-1:0];
               quo_q <= {quo_q[DW-2:0], 1'b1};
            end else begin
               rem_q <= shifted[SW-1:0];
               quo_q <= {quo_q[DW-2:0], 1'b0};
            end
            cnt_q <= cnt_q - 1'b1;
         end else begin
            act_q <= 1'b0;
         end
      end
   end

   assign fin      = act_q && (cnt_q == '0);
   assign quotient = quo_q;
endmodule

// File: rtl/refper_pll_stage.sv
module refper_pll_stage import refper_pkg::*; #(
   parameter int PW = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [PW-1:0]        in_period,
   input  logic                 bypass,
   input  logic                 off,
   input  logic [PLL_MUL_W-1:0] mult,
   output logic                 fin,
   output logic [PW-1:0]        period
);
   logic [PW-1:0] quo;

   refper_divider #(.DW(PW), .SW(PLL_MUL_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .dividend (in_period),
      .divisor  (mult),
      .fin      (fin),
      .quotient (quo)
   );

   // bypass wins over the disable bits; a zero multiplier stops the clock
   always_comb begin
      if (bypass)
         period = in_period;
      else if (off || (mult == '0))
         period = '0;
      else
         period = quo;
   end
endmodule

// File: rtl/refper_out_stage.sv
module refper_out_stage import refper_pkg::*; #(
   parameter int PW = 24,
   parameter int OW = PW + CK_DIV_W
) (
   input  logic [NUM_PLL-1:0][PW-1:0] pll_period,
   input  logic [CK_SRC_W-1:0]        src,
   input  logic [CK_DIV_W-1:0]        div,
   input  logic                       en,
   output logic [OW-1:0]              period
);
   logic [PW-1:0]       sel_period;
   logic [CK_DIV_W-1:0] eff_div;

   always_comb begin
      unique case (src_e'(src))
         SRC_IO_A, SRC_IO_B: sel_period = pll_period[PLL_IO];
         SRC_CPU:            sel_period = pll_period[PLL_CPU];
         default:            sel_period = pll_period[PLL_MEM];
      endcase
      eff_div = (div == '0) ? CK_DIV_W'(1) : div;
      period  = en ? (OW'(sel_period) * OW'(eff_div)) : '0;
   end
endmodule

// File: rtl/refper_calc.sv
module refper_calc import refper_pkg::*; #(
   parameter int PW = 24,
   parameter int CW = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [PW-1:0]          in_period,
   input  logic [CW-1:0]          io_pll_ctrl,
   input  logic [CW-1:0]          cpu_pll_ctrl,
   input  logic [CW-1:0]          mem_pll_ctrl,
   input  logic [CW-1:0]          clk_ctrl,
   output logic                   busy,
   output logic                   done,
   output logic [PW+CK_DIV_W-1:0] out0_period,
   output logic [PW+CK_DIV_W-1:0] out1_period
);
   localparam int OW = PW + CK_DIV_W;

   if (CW < PLL_MUL_LSB + PLL_MUL_W) begin : g_bad_cw
      $error("refper_calc: CW too narrow for the multiplier field");
   end
   if (PW < 2) begin : g_bad_pw
      $error("refper_calc: PW must be at least 2");
   end

   calc_st_e                   st_q;
   logic                       pend_q;
   logic [PW-1:0]              snap_in_q;
   logic [NUM_PLL-1:0][CW-1:0] snap_pll_q;
   logic [CW-1:0]              snap_ck_q;
   logic [NUM_PLL-1:0][CW-1:0] live_pll;
   logic                       changed;
   logic                       start;
   logic [NUM_PLL-1:0]         fin;
   logic [NUM_PLL-1:0][PW-1:0] pll_period;
   logic [NUM_OUT-1:0][OW-1:0] out_calc;
   logic [NUM_OUT-1:0][OW-1:0] out_q;
   logic                       busy_q, done_q;

   assign live_pll[PLL_IO]  = io_pll_ctrl;
   assign live_pll[PLL_CPU] = cpu_pll_ctrl;
   assign live_pll[PLL_MEM] = mem_pll_ctrl;

   assign changed = pend_q || (in_period != snap_in_q) ||
                    (live_pll != snap_pll_q) || (clk_ctrl != snap_ck_q);
   assign start   = (st_q == CALC_LOAD);

   for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll
      refper_pll_stage #(.PW(PW)) u_pll (
         .clk       (clk),
         .rst_n     (rst_n),
         .start     (start),
         .in_period (snap_in_q),
         .bypass    (snap_pll_q[p][PLL_BYP_BIT]),
         .off       (snap_pll_q[p][PLL_RST_BIT] | snap_pll_q[p][PLL_PD_BIT]),
         .mult      (snap_pll_q[p][PLL_MUL_LSB +: PLL_MUL_W]),
         .fin       (fin[p]),
         .period    (pll_period[p])
      );
   end

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      refper_out_stage #(.PW(PW), .OW(OW)) u_out (
         .pll_period (pll_period),
         .src        (snap_ck_q[CK_SRC_LSB +: CK_SRC_W]),
         .div        (snap_ck_q[CK_DIV_LSB +: CK_DIV_W]),
         .en         (snap_ck_q[CK_EN_LSB + o]),
         .period     (out_calc[o])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= CALC_IDLE;
         pend_q     <= 1'b1;
         snap_in_q  <= '0;
         snap_pll_q <= '0;
         snap_ck_q  <= '0;
         out_q      <= '0;
         busy_q     <= 1'b0;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            CALC_IDLE: if (changed) begin
               snap_in_q  <= in_period;
               snap_pll_q <= live_pll;
               snap_ck_q  <= clk_ctrl;
               pend_q     <= 1'b0;
               busy_q     <= 1'b1;
               st_q       <= CALC_LOAD;
            end
            CALC_LOAD: st_q <= CALC_RUN;
            default: if (&fin) begin
               out_q  <= out_calc;
               done_q <= 1'b1;
               busy_q <= 1'b0;
               st_q   <= CALC_IDLE;
            end
         endcase
      end
   end

   assign busy        = busy_q;
   assign done        = done_q;
   assign out0_period = out_q[0];
   assign out1_period = out_q[1];
endmodule

// File: rtl/refper_calc_chk.sv
module refper_calc_chk #(
   parameter int OW = 30
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic [OW-1:0] out0_period,
   input logic [OW-1:0] out1_period
);
   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R8
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));

   // R8
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(out0_period) && $stable(out1_period)));
endmodule

bind refper_calc refper_calc_chk #(.OW(OW)) u_refper_calc_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .done        (done),
   .out0_period (out0_period),
   .out1_period (out1_period)
);

// File: tb/test_refper_calc.sv
`timescale 1ns/1ps
module test_refper_calc;
   localparam int PW = 24;
   localparam int CW = 32;
   localparam int OW = 30;
   localparam int NV = 11;

   typedef struct packed {
      logic [PW-1:0] p;
      logic [CW-1:0] io;
      logic [CW-1:0] cpu;
      logic [CW-1:0] mem;
      logic [CW-1:0] ck;
      logic [OW-1:0] e0;
      logic [OW-1:0] e1;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      // R9 R6 R5: reset words, 2600/26=100, div 63
      '{24'd2600, 32'h0001A008, 32'h0001A008, 32'h0001A008, 32'h00003F03, 30'd6300, 30'd6300},
      // R1: bypass, div 2
      '{24'd1000, 32'h00010010, 32'h0001A008, 32'h0001A008, 32'h00000203, 30'd2000, 30'd2000},
      // R1 R5: bypass beats reset, only output 0 enabled
      '{24'd1000, 32'h00010011, 32'h0001A008, 32'h0001A008, 32'h00000101, 30'd1000, 30'd0},
      // R2 R4: io in reset, select code 1 is io
      '{24'd1000, 32'h00005001, 32'h00004000, 32'h00002000, 32'h00000313, 30'd0, 30'd0},
      // R4 R5: cpu 250 x3, only output 1 enabled
      '{24'd1000, 32'h00005001, 32'h00004000, 32'h00002000, 32'h00000322, 30'd0, 30'd750},
      // R4 R6: memory 500, divisor 0 as 1
      '{24'd1000, 32'h00005001, 32'h00004000, 32'h00002000, 32'h00000033, 30'd500, 30'd500},
      // R2: io powered down
      '{24'd1000, 32'h00005002, 32'h00004000, 32'h00002000, 32'h00000103, 30'd0, 30'd0},
      // R3: multiplier zero
      '{24'd1000, 32'h00000000, 32'h00004000, 32'h00002000, 32'h00000103, 30'd0, 30'd0},
      // R3 R6: 1000/7=142 floor, x63
      '{24'd1000, 32'h00007000, 32'h00004000, 32'h00002000, 32'h00003F03, 30'd8946, 30'd8946},
      // R6: widest product
      '{24'hFFFFFF, 32'h00001000, 32'h00004000, 32'h00002000, 32'h00003F03, 30'd1056964545, 30'd1056964545},
      // R3: multiplier 127
      '{24'hFFFFFF, 32'h0007F000, 32'h00004000, 32'h00002000, 32'h00000103, 30'd132104, 30'd132104}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b1;
   logic [PW-1:0] in_period = '0;
   logic [CW-1:0] io_pll_ctrl = '0, cpu_pll_ctrl = '0, mem_pll_ctrl = '0, clk_ctrl = '0;
   logic          busy, done;
   logic [OW-1:0] out0_period, out1_period;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   refper_calc #(.PW(PW), .CW(CW)) i_refper_calc (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_period    (in_period),
      .io_pll_ctrl  (io_pll_ctrl),
      .cpu_pll_ctrl (cpu_pll_ctrl),
      .mem_pll_ctrl (mem_pll_ctrl),
      .clk_ctrl     (clk_ctrl),
      .busy         (busy),
      .done         (done),
      .out0_period  (out0_period),
      .out1_period  (out1_period)
   );

   task automatic check(input string req, input logic [OW-1:0] got, input logic [OW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (done !== 1'b1 && n < 200) begin
         @(negedge clk);
         n++;
      end
      check(req, {29'd0, done}, 30'd1);
   endtask

   task automatic apply(input vec_t v);
      in_period    = v.p;
      io_pll_ctrl  = v.io;
      cpu_pll_ctrl = v.cpu;
      mem_pll_ctrl = v.mem;
      clk_ctrl     = v.ck;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      logic [OW-1:0] hold0;
      in_period    = 24'd3000;
      io_pll_ctrl  = 32'h0001A008;
      cpu_pll_ctrl = 32'h0001A008;
      mem_pll_ctrl = 32'h0001A008;
      clk_ctrl     = 32'h00003F03;
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R7: reset state
      check("R7 out0 in reset", out0_period, '0);
      check("R7 out1 in reset", out1_period, '0);
      check("R7 busy in reset", {29'd0, busy}, '0);
      check("R7 done in reset", {29'd0, done}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7 busy after release", {29'd0, busy}, 30'd1);
      wait_done("R7 done after release");
      // R9: 3000/26=115, x63
      check("R7 R9 out0 after release", out0_period, 30'd7245);
      check("R7 out1 after release", out1_period, 30'd7245);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         apply(VECS[i]);
         hold0 = out0_period;
         @(negedge clk);
         check($sformatf("R8 busy vector %0d", i), {29'd0, busy}, 30'd1);
         check($sformatf("R8 out0 held vector %0d", i), out0_period, hold0);
         wait_done($sformatf("R8 done vector %0d", i));
         check($sformatf("vector %0d out0", i), out0_period, VECS[i].e0);
         check($sformatf("vector %0d out1", i), out1_period, VECS[i].e1);
         @(negedge clk);
         check($sformatf("R8 done one cycle vector %0d", i), {29'd0, done}, '0);
      end

      // R9: only ignored bits set around multiplier 7 on the io PLL
      @(negedge clk);
      in_period   = 24'd1000;
      io_pll_ctrl = 32'hFFF87FEC;
      clk_ctrl    = 32'h00000103;
      wait_done("R9 done ignored bits");
      check("R9 out0 ignored bits", out0_period, 30'd142);
      check("R9 out1 ignored bits", out1_period, 30'd142);
      // R9: changing an unselected PLL word leaves outputs unchanged
      @(negedge clk);
      cpu_pll_ctrl = 32'h80004001;
      wait_done("R9 done unselected change");
      check("R9 out0 unselected change", out0_period, 30'd142);

      // R7: reset in the middle of a calculation
      @(negedge clk);
      io_pll_ctrl = 32'h00002000;
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R7 out0 mid-run reset", out0_period, '0);
      check("R7 busy mid-run reset", {29'd0, busy}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      wait_done("R7 done after mid-run reset");
      check("R7 out0 after mid-run reset", out0_period, 30'd500);
      check("R7 out1 after mid-run reset", out1_period, 30'd500);

      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end
endmodule